// File: doc/BRIEF.md
# Serial Frame Responder

This block stands in for a 16-bit load-then-shift register on the slave side of a simple three-wire link. A remote master raises a frame request line, then sends a train of shift clocks. The block runs on its own, faster system clock and oversamples both master lines. On the rising edge of the frame request it captures a parallel word and presents bit 0 at once. Each later rising shift-clock edge presents the next bit, least significant first. The bit stays steady through the falling edge, where the master is expected to sample it.

After the sixteenth shift-clock rise, the serial line is forced low and the block waits for the next request. A frame that stalls because a clock pulse was lost is abandoned after a programmable number of system clocks, so later frames stay aligned. A build-time option drives the line by toggling it with a pre-encoded word instead of shifting the plain word out. Both options give the same waveform on the pin.

Top module: `serial_frame_responder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ser_out`, `frame_done` and `timeout_err` are all 0.
- R2: Within 4 system clocks of a rising edge on `frame_req_in`, the block captures `load_word` and drives bit 0 of it on `ser_out`.
- R3: During a frame, each rising edge of `shift_clk_in` moves `ser_out` forward by exactly one bit, in the order bit 1, bit 2, ..., bit 15. A shift clock held high advances it no further.
- R4: During a frame, `ser_out` changes only in the cycle after a detected shift-clock rise or request rise. It therefore holds its value from shortly after a rising shift-clock edge until the next one.
- R5: The 16th shift-clock rise of a frame drives `ser_out` to 0, gives a one-cycle `frame_done` pulse and returns the block to idle.
- R6: Shift-clock edges with no frame in progress are ignored: `ser_out` stays 0 and `frame_done` does not pulse.
- R7: If no shift-clock rise arrives for `TIMEOUT_CYC` system clocks during a frame, the block drives `ser_out` to 0, gives a one-cycle `timeout_err` pulse and goes idle. The next request starts a correctly aligned frame.
- R8: A request rise during a frame reloads `load_word` and restarts at bit 0. A full 16 rises are then needed to finish.
- R9: With `OUT_MODE` set to the toggle variant, the word is encoded as w XOR (w << 1) and `ser_out` is inverted on a shift-clock rise only when the current encoded bit is 1. The waveform on `ser_out` is identical to the direct variant.
- R10: Changes on `load_word` after the capture have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| load_word | input | WORD_W | Parallel word captured at a request rise |
| frame_req_in | input | 1 | Asynchronous frame request from the master |
| shift_clk_in | input | 1 | Asynchronous shift clock from the master |
| ser_out | output | 1 | Registered serial data line |
| frame_done | output | 1 | One-cycle pulse when a frame completes |
| timeout_err | output | 1 | One-cycle pulse when a stalled frame is abandoned |

## Verification
The bench builds two copies side by side on the same stimulus, with the default 16-bit word and a shortened `TIMEOUT_CYC` of 64. One copy uses the direct output and the other the toggle output, so every bit check also compares the two variants (R9). The shift-clock phases are 8 system clocks, which sets the oversampling ratio at the low end of the stated budget. The short timeout lets the bench reach an abandoned frame in about a hundred cycles, while still keeping it well above both a normal clock phase and a deliberately stretched high phase.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic {OUT_DIRECT = 1'b0, OUT_TOGGLE = 1'b1} out_mode_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_SHIFT = 1'b1} frame_state_e;
endpackage

// File: rtl/sfr_edge_sync.sv
// Multi-flop synchronizer followed by a rising-edge detector.
module sfr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_in};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/sfr_frame_ctrl.sv
// Frame sequencing: bit index, stall timeout and frame end decisions.
module sfr_frame_ctrl
  import sfr_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic req_rise,
  input  logic sck_rise,
  output logic do_load,
  output logic do_step,
  output logic do_clear,
  output logic busy,
  output logic done_pulse,
  output logic abort_pulse
);
  localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(WORD_W - 1);
  localparam logic [TW-1:0] TO_LIMIT = TW'(TIMEOUT_CYC - 1);

  frame_state_e    state_q;
  logic [IW-1:0]   idx_q;
  logic [TW-1:0]   tcnt_q;
  logic            finish, abort;

  always_comb begin
    do_load = req_rise;
    finish  = (state_q == ST_SHIFT) && sck_rise && !req_rise && (idx_q == LAST_IDX);
    do_step = (state_q == ST_SHIFT) && sck_rise && !req_rise && (idx_q != LAST_IDX);
    abort   = (state_q == ST_SHIFT) && !sck_rise && !req_rise && (tcnt_q == TO_LIMIT);
    do_clear = finish || abort;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      tcnt_q      <= '0;
      done_pulse  <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      done_pulse  <= finish;
      abort_pulse <= abort;
      if (do_load) begin
        state_q <= ST_SHIFT;
        idx_q   <= '0;
        tcnt_q  <= '0;
      end else if (do_clear) begin
        state_q <= ST_IDLE;
        idx_q   <= '0;
        tcnt_q  <= '0;
      end else if (do_step) begin
        idx_q  <= idx_q + 1'b1;
        tcnt_q <= '0;
      end else if (state_q == ST_SHIFT) begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign busy = (state_q == ST_SHIFT);
endmodule

// File: rtl/sfr_out_path.sv
// Serial output register; the variant is picked by OUT_MODE.
module sfr_out_path
  import sfr_pkg::*;
#(
  parameter int        WORD_W   = 16,
  parameter out_mode_e OUT_MODE = OUT_DIRECT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  input  logic              do_load,
  input  logic              do_step,
  input  logic              do_clear,
  output logic              dout
);
  logic [WORD_W-1:0] sh_q;

  generate
    if (OUT_MODE == OUT_TOGGLE) begin : g_toggle
      logic [WORD_W-1:0] enc;
      assign enc = word ^ {word[WORD_W-2:0], 1'b0};
      always_ff @(posedge clk) begin
        if (rst) begin
          sh_q <= '0;
          dout <= 1'b0;
        end else if (do_load) begin
          sh_q <= enc;
          dout <= word[0];
        end else if (do_clear) begin
          sh_q <= '0;
          dout <= 1'b0;
        end else if (do_step) begin
          sh_q <= sh_q >> 1;
          dout <= dout ^ sh_q[1];
        end
      end
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) begin
          sh_q <= '0;
          dout <= 1'b0;
        end else if (do_load) begin
          sh_q <= word;
          dout <= word[0];
        end else if (do_clear) begin
          sh_q <= '0;
          dout <= 1'b0;
        end else if (do_step) begin
          sh_q <= sh_q >> 1;
          dout <= sh_q[1];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/serial_frame_responder.sv
module serial_frame_responder
  import sfr_pkg::*;
#(
  parameter int        WORD_W      = 16,
  parameter int        SYNC_STAGES = 2,
  parameter int        TIMEOUT_CYC = 1024,
  parameter out_mode_e OUT_MODE    = OUT_DIRECT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] load_word,
  input  logic              frame_req_in,
  input  logic              shift_clk_in,
  output logic              ser_out,
  output logic              frame_done,
  output logic              timeout_err
);
  logic lat_rise, sck_rise;
  logic do_load, do_step, do_clear, busy;

  sfr_edge_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .async_in(frame_req_in), .rise(lat_rise)
  );

  sfr_edge_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk(clk), .rst(rst), .async_in(shift_clk_in), .rise(sck_rise)
  );

  sfr_frame_ctrl #(.WORD_W(WORD_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .req_rise(lat_rise), .sck_rise(sck_rise),
    .do_load(do_load), .do_step(do_step), .do_clear(do_clear), .busy(busy),
    .done_pulse(frame_done), .abort_pulse(timeout_err)
  );

  sfr_out_path #(.WORD_W(WORD_W), .OUT_MODE(OUT_MODE)) u_out (
    .clk(clk), .rst(rst), .word(load_word), .do_load(do_load),
    .do_step(do_step), .do_clear(do_clear), .dout(ser_out)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
  input logic clk,
  input logic rst,
  input logic ser_out,
  input logic frame_done,
  input logic timeout_err,
  input logic busy,
  input logic lat_rise,
  input logic sck_rise
);
  // R4
  hold_between_edges_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(sck_rise) && !$past(lat_rise)) |-> $stable(ser_out));

  // R5
  done_line_low_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (!ser_out && !busy));

  // R5
  done_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(busy));

  // R6
  idle_line_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ser_out);

  // R7
  abort_line_low_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> (!ser_out && !busy));

  // R7
  single_end_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !(frame_done && timeout_err));

  // R5
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
endmodule

bind serial_frame_responder sfr_checker u_chk (
  .clk(clk), .rst(rst), .ser_out(ser_out), .frame_done(frame_done),
  .timeout_err(timeout_err), .busy(busy), .lat_rise(lat_rise), .sck_rise(sck_rise)
);

// File: tb/sim_serial_frame_responder.sv
module sim_serial_frame_responder;
  import sfr_pkg::*;
  localparam int CLK_PER = 10;
  localparam int W       = 16;
  localparam int TO      = 64;
  localparam int PH      = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] load_word = '0;
  logic req = 1'b0, sck = 1'b0;
  logic so0, so1, fd0, fd1, te0, te1;
  int total = 0, bad = 0;
  int done0 = 0, done1 = 0, to0 = 0, to1 = 0;

  always #(CLK_PER/2) clk = ~clk;

  serial_frame_responder #(.WORD_W(W), .TIMEOUT_CYC(TO), .OUT_MODE(OUT_DIRECT)) u0 (
    .clk(clk), .rst(rst), .load_word(load_word), .frame_req_in(req),
    .shift_clk_in(sck), .ser_out(so0), .frame_done(fd0), .timeout_err(te0)
  );
  serial_frame_responder #(.WORD_W(W), .TIMEOUT_CYC(TO), .OUT_MODE(OUT_TOGGLE)) u1 (
    .clk(clk), .rst(rst), .load_word(load_word), .frame_req_in(req),
    .shift_clk_in(sck), .ser_out(so1), .frame_done(fd1), .timeout_err(te1)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (fd0) done0++;
      if (fd1) done1++;
      if (te0) to0++;
      if (te1) to1++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_line(input string tag, input logic exp);
    chk({tag, " direct"}, int'(so0), int'(exp));
    chk({"R9 ", tag, " toggle"}, int'(so1), int'(exp));
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_req(input logic [W-1:0] w);
    load_word = w;
    req = 1'b1;
    wait_n(6);
    chk_line("R2 bit0", w[0]);
    wait_n(2);
    req = 1'b0;
    wait_n(4);
  endtask

  // one full shift-clock pulse; checks the bit after the rise and before the next rise
  task automatic pulse_chk(input string tag, input logic exp);
    sck = 1'b1;
    wait_n(6);
    chk_line(tag, exp);
    wait_n(PH - 6);
    sck = 1'b0;
    wait_n(PH - 1);
    chk_line({"R4 ", tag}, exp);
    wait_n(1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    wait_n(4);
    chk_line("R1 reset line", 1'b0);
    chk("R1 reset done", int'(fd0 | fd1), 0);
    chk("R1 reset timeout", int'(te0 | te1), 0);
    rst = 1'b0;
    wait_n(1);
    chk_line("R1 after reset", 1'b0);
    wait_n(4);
  endtask

  task automatic t_frame(input logic [W-1:0] w);
    int d0;
    d0 = done0;
    send_req(w);
    load_word = ~w; // R10: must not disturb the frame
    for (int k = 1; k < W; k++) pulse_chk($sformatf("R3 R10 bit%0d", k), w[k]);
    pulse_chk("R5 end low", 1'b0);
    chk("R5 frame_done direct", done0 - d0, 1);
    chk("R9 R5 frame_done toggle", done1 - d0, 1);
  endtask

  task automatic t_held_high(input logic [W-1:0] w);
    send_req(w);
    sck = 1'b1;
    wait_n(40);
    chk_line("R3 held high", w[1]);
    sck = 1'b0;
    wait_n(PH);
    for (int k = 2; k < W; k++) pulse_chk($sformatf("R3 held bit%0d", k), w[k]);
    pulse_chk("R5 held end", 1'b0);
  endtask

  task automatic t_idle();
    int d0;
    d0 = done0;
    for (int k = 0; k < 5; k++) pulse_chk("R6 idle", 1'b0);
    chk("R6 no done", done0 - d0, 0);
  endtask

  task automatic t_timeout(input logic [W-1:0] w);
    int t0, d0;
    t0 = to0;
    d0 = done0;
    send_req(w);
    for (int k = 1; k < 6; k++) pulse_chk($sformatf("R7 pre bit%0d", k), w[k]);
    wait_n(TO + 30);
    chk("R7 timeout direct", to0 - t0, 1);
    chk("R9 R7 timeout toggle", to1 - t0, 1);
    chk_line("R7 line low", 1'b0);
    chk("R7 no done", done0 - d0, 0);
    t_frame(16'h3C5A); // realigned frame
  endtask

  task automatic t_reload(input logic [W-1:0] a, input logic [W-1:0] b);
    int d0;
    d0 = done0;
    send_req(a);
    for (int k = 1; k < 8; k++) pulse_chk($sformatf("R8 first bit%0d", k), a[k]);
    send_req(b);
    for (int k = 1; k < W; k++) pulse_chk($sformatf("R8 reload bit%0d", k), b[k]);
    chk("R8 no early done", done0 - d0, 0);
    pulse_chk("R8 end", 1'b0);
    chk("R8 done once", done0 - d0, 1);
  endtask

  initial begin
    t_reset();
    t_frame(16'h8001);
    t_frame(16'hA5C3);
    t_frame(16'hFFFF);
    t_frame(16'h0000);
    t_held_high(16'h0F0E);
    t_idle();
    t_timeout(16'h6DB6);
    t_reload(16'hFFFF, 16'h1234);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    total++;
    bad++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule